// File: doc/BRIEF.md
# Pairwise-Order LRU Victim Tracker

This block keeps exact least-recently-used order for a single set of a B-way cache. For every pair of ways (i, j) with i < j it stores one bit that means "way i was used more recently than way j". The bit for the mirrored pair (j, i) is never stored, because it is always the complement. A B-way set therefore needs B(B-1)/2 flops, which is six for four ways. The lookup logic pulses an access strobe with the index of the way it touched. The tracker then marks that way as newer than every other way: it sets the stored bits where that way is the lower index and clears the ones where it is the higher index.

The victim index is combinational and is valid in every cycle. If any way is flagged invalid, the lowest-numbered invalid way is offered, so that empty slots fill first. Once all ways are valid, the victim is the one way that every other way is newer than: its stored row bits are all zero and its stored column bits are all one. Tag compare and data arrays belong to the surrounding cache.

Top module: `lru_matrix_tracker`

## Requirements
- R1: While reset is active and after it is released, all stored order bits are zero. This encodes the order 3, 2, 1, 0 from newest to oldest, so with all ways valid the victim is way 0.
- R2: An access to way a leaves a as the newest way. With all ways valid, the victim in the cycle after the access is never a.
- R3: With all ways valid, the victim is always the way whose most recent access is oldest, taking the reset order of R1 as the starting history. This is exact LRU over any sequence of accesses.
- R4: If one or more bits of the valid vector are 0, the victim is the lowest-numbered invalid way, whatever the recency state. Bit k of the valid vector belongs to way k.
- R5: While the access strobe is low, the recency state does not change, whatever the value on the way index.
- R6: The victim follows changes of the valid vector combinationally, in the same cycle and without a clock edge.
- R7: An access changes the victim only from the rising clock edge at which the strobe is sampled high. Before that edge the victim still reflects the old order.
- R8: Repeated accesses to the way that is already newest leave the relative order of all other ways unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset, clears the order bits |
| accessValid | input | 1 | One-cycle strobe marking an access to the set |
| accessWay | input | WAY_W | Index of the accessed way |
| wayValid | input | NUM_WAYS | Bit k is 1 when way k holds a valid line |
| victimWay | output | WAY_W | Way to replace next |

## Verification
The main function is driven with a fixed ten-access sequence of ways. The sequence includes accesses to the current oldest way and to a middle way, and two back-to-back accesses to the newest way. Comparing the victim after each step against an independently worked LRU list separates true LRU from FIFO or most-recent-only tracking. Valid-vector patterns with one invalid way and with two invalid ways, applied without a clock edge, show that invalid ways take priority, that the lowest invalid index wins, and that the selection is combinational. An idle strobe with a changing index, together with a check just before and just after the update edge, pins down when the state changes.

// File: rtl/lru_pkg.sv
package lru_pkg;

  typedef struct packed {
    logic update;
  } ctrlStrobes_t;

  function automatic int pairIdx(input int i, input int j, input int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/lru_matrix_dp.sv
module lru_matrix_dp #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int NUM_PAIRS = (NUM_WAYS * (NUM_WAYS - 1)) / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  lru_pkg::ctrlStrobes_t     strobes,
  input  logic [WAY_W-1:0]          accessWay,
  output logic [NUM_PAIRS-1:0]      orderBits,
  output logic [NUM_WAYS-1:0]       lruVec
);

  logic [NUM_PAIRS-1:0] nextBits;

  always_comb begin
    int aw;
    aw = int'(accessWay);
    nextBits = orderBits;
    if (strobes.update) begin
      for (int i = 0; i < NUM_WAYS; i++) begin
        for (int j = i + 1; j < NUM_WAYS; j++) begin
          if (i == aw) begin
            nextBits[lru_pkg::pairIdx(i, j, NUM_WAYS)] = 1'b1;
          end else if (j == aw) begin
            nextBits[lru_pkg::pairIdx(i, j, NUM_WAYS)] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orderBits <= '0;
    end else begin
      orderBits <= nextBits;
    end
  end

  // A way is oldest when it is newer than nobody (stored row all zero)
  // and everybody below it is newer (stored column all one).
  always_comb begin
    for (int k = 0; k < NUM_WAYS; k++) begin
      lruVec[k] = 1'b1;
      for (int j = k + 1; j < NUM_WAYS; j++) begin
        if (orderBits[lru_pkg::pairIdx(k, j, NUM_WAYS)]) lruVec[k] = 1'b0;
      end
      for (int i = 0; i < k; i++) begin
        if (!orderBits[lru_pkg::pairIdx(i, k, NUM_WAYS)]) lruVec[k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lru_ctrl.sv
module lru_ctrl #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                   accessValid,
  input  logic [WAY_W-1:0]       accessWay,
  input  logic [NUM_WAYS-1:0]    wayValid,
  input  logic [NUM_WAYS-1:0]    lruVec,
  output lru_pkg::ctrlStrobes_t  strobes,
  output logic [WAY_W-1:0]       victimWay
);

  always_comb begin
    strobes.update = accessValid && (int'(accessWay) < NUM_WAYS);
  end

  always_comb begin
    victimWay = '0;
    if (!(&wayValid)) begin
      for (int k = NUM_WAYS - 1; k >= 0; k--) begin
        if (!wayValid[k]) victimWay = WAY_W'(k);
      end
    end else begin
      for (int k = NUM_WAYS - 1; k >= 0; k--) begin
        if (lruVec[k]) victimWay = WAY_W'(k);
      end
    end
  end

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accessValid,
  input  logic [WAY_W-1:0]     accessWay,
  input  logic [NUM_WAYS-1:0]  wayValid,
  output logic [WAY_W-1:0]     victimWay
);

  localparam int NUM_PAIRS = (NUM_WAYS * (NUM_WAYS - 1)) / 2;

  lru_pkg::ctrlStrobes_t strobes;
  logic [NUM_PAIRS-1:0]  orderBits;
  logic [NUM_WAYS-1:0]   lruVec;

  lru_ctrl #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_ctrl (
    .accessValid (accessValid),
    .accessWay   (accessWay),
    .wayValid    (wayValid),
    .lruVec      (lruVec),
    .strobes     (strobes),
    .victimWay   (victimWay)
  );

  lru_matrix_dp #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .accessWay (accessWay),
    .orderBits (orderBits),
    .lruVec    (lruVec)
  );

endmodule

// File: rtl/lru_matrix_checker.sv
module lru_matrix_checker #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W = 2,
  parameter int NUM_PAIRS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accessValid,
  input logic [WAY_W-1:0]     accessWay,
  input logic [NUM_WAYS-1:0]  wayValid,
  input logic [WAY_W-1:0]     victimWay,
  input logic [NUM_PAIRS-1:0] orderBits,
  input logic [NUM_WAYS-1:0]  lruVec
);

  // R3: the stored order always names exactly one oldest way
  a_r3_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lruVec) == 1);

  // R3: with every way valid, the victim is the way the order marks oldest
  a_r3_victim_is_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (&wayValid) |-> lruVec[victimWay]);

  // R2: the way just accessed is not the next victim
  a_r2_not_just_used: assert property (@(posedge clk) disable iff (!rst_n)
    (accessValid && (&wayValid)) |=> (!(&wayValid) || victimWay != $past(accessWay)));

  // R4: with an invalid way present, the victim is one of the invalid ways
  a_r4_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&wayValid)) |-> !wayValid[victimWay]);

  // R5: without an access strobe the order bits hold
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !accessValid |=> $stable(orderBits));

endmodule

bind lru_matrix_tracker lru_matrix_checker #(
  .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .NUM_PAIRS(NUM_PAIRS)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .accessValid (accessValid),
  .accessWay   (accessWay),
  .wayValid    (wayValid),
  .victimWay   (victimWay),
  .orderBits   (orderBits),
  .lruVec      (lruVec)
);

// File: tb/tb_lru_matrix_tracker.sv
`timescale 1ns/1ps
module tb_lru_matrix_tracker;

  localparam int NUM_WAYS = 4;
  localparam int WAY_W = 2;
  localparam int STEPS = 10;
  // accessed way per step, and the oldest way afterwards (worked LRU lists)
  localparam int seqWay [STEPS] = '{0, 1, 3, 2, 1, 0, 3, 3, 2, 1};
  localparam int seqVic [STEPS] = '{1, 2, 2, 0, 0, 3, 2, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accessValid = 1'b0;
  logic [WAY_W-1:0] accessWay = '0;
  logic [NUM_WAYS-1:0] wayValid = '1;
  logic [WAY_W-1:0] victimWay;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lru_matrix_tracker #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) dut (
    .clk(clk), .rst_n(rst_n), .accessValid(accessValid),
    .accessWay(accessWay), .wayValid(wayValid), .victimWay(victimWay)
  );

  task automatic check(input string req, input int expected);
    checks++;
    if (int'(victimWay) != expected) begin
      errors++;
      $display("FAIL %s: victim actual %0d expected %0d", req, victimWay, expected);
    end
  endtask

  task automatic doAccess(input int w);
    @(negedge clk);
    accessValid = 1'b1;
    accessWay = WAY_W'(w);
    @(negedge clk);
    accessValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    check("R1 reset victim", 0);

    for (int s = 0; s < STEPS; s++) begin
      doAccess(seqWay[s]);
      check((s == 7) ? "R8 repeat newest" : "R3 lru order", seqVic[s]);
      checks++;
      if (int'(victimWay) == seqWay[s]) begin
        errors++;
        $display("FAIL R2: victim actual %0d expected not %0d", victimWay, seqWay[s]);
      end
    end
    // order oldest-first is now 0,3,2,1

    // R5: idle strobe with a moving index
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      accessWay = WAY_W'(c);
    end
    @(negedge clk);
    check("R5 idle holds", 0);

    // R7: no change before the edge, change right after it
    @(negedge clk);
    accessValid = 1'b1;
    accessWay = 2'd0;
    #2;
    check("R7 before edge", 0);
    @(posedge clk);
    #2;
    check("R7 after edge", 3);
    @(negedge clk);
    accessValid = 1'b0;
    // order oldest-first 3,2,1,0

    // R6 and R4: invalid ways win, combinationally
    wayValid = 4'b1011;
    #1;
    check("R6 R4 single invalid", 2);
    wayValid = 4'b0101;
    #1;
    check("R4 lowest invalid", 1);
    wayValid = 4'b0111;
    #1;
    check("R4 top invalid", 3);
    wayValid = 4'b1111;
    #1;
    check("R6 back to order", 3);

    // R1: reset in mid-operation restores way 0 as oldest
    doReset();
    check("R1 reset again", 0);
    doAccess(0);
    check("R1 R3 first access after reset", 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule